// File: doc/BRIEF.md
# Strided Capture Subset Extractor

The block prepares a readout image inside a byte-wide, single-port memory that it shares with a host reader. A one-cycle start pulse comes with three 8-bit controls: a stride for the first window, a stride for the second window and a shift factor. The block then pulls two decimated 500-byte windows out of the raw capture area that begins at 0x6000 and holds 5000 bytes. The first window starts at capture offset zero. The second window starts at offset 5 × stride1 × shift. Both windows are packed one after the other from 0x4000 upward.

After the two windows the block writes a three-byte end marker. It then copies 100 bytes, taken from 0x4320 onward, to close the image. When the image is complete it parks its read pointer at 0x4000. From then on, each read-advance pulse moves the pointer forward by one. The memory address follows the pointer, so the host sees the bytes in order. The pointer runs up to 0x7FFF and then returns to 0x4000.

A capture offset that would fall past the last raw sample reads the last sample instead. The memory is expected to return read data one clock after the address is presented.

Top module: `subset_extractor`

## Requirements
- R1: A start pulse while idle raises `busy` on the next clock edge. `busy` then stays high for exactly 4×500+3+2×100 = 2203 cycles.
- R2: For i in 0..499, byte 0x4000+i receives the capture byte at 0x6000+min(i×stride1, 4999).
- R3: For i in 0..499, byte 0x41F4+i receives the capture byte at 0x6000+min(5×stride1×shift + i×stride2, 4999).
- R4: Bytes 0x43E8, 0x43E9 and 0x43EA receive 0x01, 0xFE and 0x80, in that order.
- R5: For k in 0..99, byte 0x43EB+k receives the value held at 0x4320+k once the second window is written.
- R6: Writes occur only while busy and only to 0x4000..0x444E. Every copied byte uses one read cycle and then one write cycle; read data is taken one clock after its address.
- R7: When a fill ends, `rd_ptr` is 0x4000. While idle, `mem_addr` equals `rd_ptr`, no write is issued, and `rd_data` returns the byte at the pointer one clock later.
- R8: While idle, each cycle with `rd_adv` high and `start` low adds one to `rd_ptr`. From 0x7FFF the pointer goes to 0x4000.
- R9: While busy, `start` and `rd_adv` have no effect. The fill in progress keeps the controls latched at its own start, and the pointer still ends at 0x4000.
- R10: After reset, `busy` is low, `rd_ptr` is 0x4000 and `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fill (pulse) |
| step1 | input | 8 | Stride of the first window |
| step2 | input | 8 | Stride of the second window |
| shift | input | 8 | Multiplier for the second window's start |
| rd_adv | input | 1 | Move the read pointer forward by one |
| busy | output | 1 | Fill in progress |
| rd_ptr | output | 16 | Current readout address |
| rd_data | output | 8 | Byte read at the pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle latency |

## Verification
A fault in the offset accumulator or the clamp shows up as wrong bytes in the windows. These are visible only after the 2203-cycle fill, when the stored image is compared, or byte by byte during readout. A fault in the destination counter or in the phase bit appears at once as a write outside the fill region, or as a write without a read before it. It also changes the length of `busy`, which is measured on every run. Pointer faults show up on the first advance that follows, or at the wrap from 0x7FFF, which the sweep reaches directly.

// File: rtl/subset_extractor.sv
module subset_extractor #(
  parameter int ADDR_W   = 16,
  parameter int STEP_W   = 8,
  parameter int OFF_W    = 20,
  parameter int RAW_LEN  = 5000,
  parameter int SUB_LEN  = 500,
  parameter int TAIL_LEN = 100,
  parameter int SHIFT_MUL = 5,
  parameter logic [ADDR_W-1:0] SRC_BASE = 'h6000,
  parameter logic [ADDR_W-1:0] DST_BASE = 'h4000,
  parameter logic [ADDR_W-1:0] TAIL_SRC = 'h4320,
  parameter logic [ADDR_W-1:0] PTR_TOP  = 'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] step1,
  input  logic [STEP_W-1:0] step2,
  input  logic [STEP_W-1:0] shift,
  input  logic              rd_adv,
  output logic              busy,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int IDX_W    = $clog2(SUB_LEN > TAIL_LEN ? SUB_LEN : TAIL_LEN) + 1;
  localparam int FILL_LEN = 2*SUB_LEN + 3 + TAIL_LEN;
  localparam logic [ADDR_W-1:0] FILL_END = ADDR_W'(DST_BASE + FILL_LEN - 1);
  localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(RAW_LEN - 1);
  localparam logic [IDX_W-1:0]  SUB_LAST  = IDX_W'(SUB_LEN - 1);
  localparam logic [IDX_W-1:0]  TAIL_LAST = IDX_W'(TAIL_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_WIN1, S_WIN2, S_MARK, S_TAIL} st_t;

  st_t               st;
  logic              wr_ph;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off, base2;
  logic [STEP_W-1:0] s1, s2;
  logic [ADDR_W-1:0] dst, ptr;
  logic [OFF_W-1:0]  off_c;
  logic [ADDR_W-1:0] src_addr, tail_addr;
  logic [7:0]        mark_b;

  assign busy      = (st != S_IDLE);
  assign rd_ptr    = ptr;
  assign rd_data   = mem_rdata;
  assign off_c     = (off > OFF_MAX) ? OFF_MAX : off;
  assign src_addr  = SRC_BASE + ADDR_W'(off_c);
  assign tail_addr = TAIL_SRC + ADDR_W'(idx);

  always_comb begin
    case (idx[1:0])
      2'd0:    mark_b = 8'h01;
      2'd1:    mark_b = 8'hFE;
      default: mark_b = 8'h80;
    endcase
  end

  always_comb begin
    mem_addr  = ptr;
    mem_we    = 1'b0;
    mem_wdata = mem_rdata;
    case (st)
      S_WIN1, S_WIN2: begin
        mem_addr = wr_ph ? dst : src_addr;
        mem_we   = wr_ph;
      end
      S_MARK: begin
        mem_addr  = dst;
        mem_we    = 1'b1;
        mem_wdata = mark_b;
      end
      S_TAIL: begin
        mem_addr = wr_ph ? dst : tail_addr;
        mem_we   = wr_ph;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wr_ph <= 1'b0;
      idx   <= '0;
      off   <= '0;
      base2 <= '0;
      s1    <= '0;
      s2    <= '0;
      dst   <= DST_BASE;
      ptr   <= DST_BASE;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) begin
            s1    <= step1;
            s2    <= step2;
            base2 <= OFF_W'(SHIFT_MUL) * OFF_W'(step1) * OFF_W'(shift);
            off   <= '0;
            idx   <= '0;
            dst   <= DST_BASE;
            wr_ph <= 1'b0;
            st    <= S_WIN1;
          end else if (rd_adv) begin
            ptr <= (ptr == PTR_TOP) ? DST_BASE : ptr + 1'b1;
          end
        end
        S_WIN1: begin
          wr_ph <= ~wr_ph;
          if (wr_ph) begin
            dst <= dst + 1'b1;
            if (idx == SUB_LAST) begin
              idx <= '0;
              off <= base2;
              st  <= S_WIN2;
            end else begin
              idx <= idx + 1'b1;
              off <= off + OFF_W'(s1);
            end
          end
        end
        S_WIN2: begin
          wr_ph <= ~wr_ph;
          if (wr_ph) begin
            dst <= dst + 1'b1;
            if (idx == SUB_LAST) begin
              idx <= '0;
              st  <= S_MARK;
            end else begin
              idx <= idx + 1'b1;
              off <= off + OFF_W'(s2);
            end
          end
        end
        S_MARK: begin
          dst <= dst + 1'b1;
          if (idx == IDX_W'(2)) begin
            idx <= '0;
            st  <= S_TAIL;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_TAIL: begin
          wr_ph <= ~wr_ph;
          if (wr_ph) begin
            dst <= dst + 1'b1;
            if (idx == TAIL_LAST) begin
              idx <= '0;
              st  <= S_IDLE;
              ptr <= DST_BASE;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_write_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && mem_addr >= DST_BASE && mem_addr <= FILL_END));

  p_read_before_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (st == S_WIN1 || st == S_WIN2 || st == S_TAIL))
      |-> ($past(busy) && !$past(mem_we)));

  p_ptr_home_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rd_ptr == DST_BASE));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && rd_adv && rd_ptr == PTR_TOP) |=> (rd_ptr == DST_BASE));

  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && rd_adv && rd_ptr != PTR_TOP)
      |=> (rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_adv) |=> ($stable(rd_ptr) || !busy));

endmodule

// File: tb/tb_subset_extractor.sv
module tb_subset_extractor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] step1 = '0, step2 = '0, shift = '0;
  logic       rd_adv = 1'b0;
  logic       busy;
  logic [15:0] rd_ptr, mem_addr;
  logic [7:0] rd_data, mem_wdata;
  logic       mem_we;
  logic [7:0] mem_rdata = '0;

  logic [7:0] mem [int];
  logic [7:0] expv [0:1102];
  int tests = 0, fails = 0, bad_wr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subset_extractor dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step1(step1), .step2(step2),
    .shift(shift), .rd_adv(rd_adv), .busy(busy), .rd_ptr(rd_ptr),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
    if (mem_we) begin
      if (mem_addr < 16'h4000 || mem_addr > 16'h444E) bad_wr = bad_wr + 1;
      mem[int'(mem_addr)] = mem_wdata;
    end
  end

  function automatic logic [7:0] src_val(int a);
    return 8'(a*37 + (a >> 7)*11 + 5);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic load_mem(logic [7:0] junk);
    for (int a = 16'h6000; a <= 16'h7387; a++) mem[a] = src_val(a);
    for (int a = 16'h7388; a <= 16'h73FF; a++) mem[a] = 8'hEE;
    for (int a = 16'h4000; a <= 16'h444E; a++) mem[a] = junk;
  endtask

  task automatic build_exp(int s1, int s2, int sh);
    for (int i = 0; i < 500; i++) begin
      int o1, o2;
      o1 = i*s1;            if (o1 > 4999) o1 = 4999;
      o2 = 5*s1*sh + i*s2;  if (o2 > 4999) o2 = 4999;
      expv[i]       = src_val(16'h6000 + o1);
      expv[500 + i] = src_val(16'h6000 + o2);
    end
    expv[1000] = 8'h01; expv[1001] = 8'hFE; expv[1002] = 8'h80;
    for (int k = 0; k < 100; k++) expv[1003 + k] = expv[16'h320 + k];
  endtask

  task automatic cmp_region(int lo, int hi, string req, string what);
    int bad = 0, first = -1;
    for (int k = lo; k <= hi; k++)
      if (mem[16'h4000 + k] !== expv[k]) begin
        bad++;
        if (first < 0) first = k;
      end
    if (first < 0) check(1'b1, req, what, 0, 0);
    else check(1'b0, req, what, int'(mem[16'h4000 + first]), int'(expv[first]));
  endtask

  task automatic run_cfg(int s1, int s2, int sh, bit disturb, logic [7:0] junk);
    int n = 0;
    load_mem(junk);
    build_exp(s1, s2, sh);
    bad_wr = 0;
    @(negedge clk);
    step1 = 8'(s1); step2 = 8'(s2); shift = 8'(sh); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1", "busy after start", int'(busy), 1);
    while (busy) begin
      @(negedge clk);
      n++;
      if (disturb && n == 40) begin
        start = 1'b1; rd_adv = 1'b1;
        step1 = 8'(s1 ^ 8'h5A); step2 = 8'(s2 + 3); shift = 8'(sh ^ 8'h0F);
      end
      if (disturb && n == 41) begin start = 1'b0; rd_adv = 1'b0; end
      if (n > 5000) break;
    end
    check(n == 2203, "R1", "busy length", n, 2203);
    cmp_region(0, 499, "R2", "first window");
    cmp_region(500, 999, "R3", "second window");
    cmp_region(1000, 1002, "R4", "end marker");
    cmp_region(1003, 1102, "R5", "copied tail");
    check(bad_wr == 0, "R6", "writes outside fill", bad_wr, 0);
    check(rd_ptr == 16'h4000, disturb ? "R9" : "R7", "pointer after fill",
          int'(rd_ptr), 16'h4000);
    begin
      int rbad = 0, ra = 0, re = 0;
      for (int k = 0; k < 1103; k++) begin
        @(negedge clk);
        if (rd_ptr !== 16'(16'h4000 + k) || rd_data !== expv[k] || mem_we !== 1'b0) begin
          if (rbad == 0) begin ra = int'(rd_data); re = int'(expv[k]); end
          rbad++;
        end
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
      end
      check(rbad == 0, "R7", "sequential readout", ra, re);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R10", "busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(rd_ptr === 16'h4000, "R10", "pointer after reset", int'(rd_ptr), 16'h4000);
    check(mem_we === 1'b0, "R10", "no write after reset", int'(mem_we), 0);

    rd_adv = 1'b1;
    repeat (5) @(negedge clk);
    rd_adv = 1'b0;
    check(rd_ptr === 16'h4005, "R8", "advance by five", int'(rd_ptr), 16'h4005);

    run_cfg(1, 1, 100, 1'b0, 8'hA5);
    run_cfg(100, 1, 2, 1'b1, 8'h3C);
    run_cfg(212, 1, 41, 1'b0, 8'hC3);
    run_cfg(255, 255, 255, 1'b0, 8'h5A);
    run_cfg(0, 0, 0, 1'b0, 8'h96);
    run_cfg(3, 7, 9, 1'b0, 8'h69);
    run_cfg(1, 255, 3, 1'b0, 8'h11);

    check(rd_ptr === 16'h444F, "R8", "pointer after readout", int'(rd_ptr), 16'h444F);
    @(negedge clk);
    rd_adv = 1'b1;
    repeat (16'h7FFF - 16'h444F) @(negedge clk);
    rd_adv = 1'b0;
    check(rd_ptr === 16'h7FFF, "R8", "pointer at top", int'(rd_ptr), 16'h7FFF);
    rd_adv = 1'b1;
    @(negedge clk);
    rd_adv = 1'b0;
    check(rd_ptr === 16'h4000, "R8", "wrap to base", int'(rd_ptr), 16'h4000);
    @(negedge clk);
    check(rd_data === expv[0], "R7", "data after wrap", int'(rd_data), int'(expv[0]));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule